// File: doc/BRIEF.md
# SPI Host Control Command Register

This block is the write-only command port of a serial controller that runs as an SPI host or SPI client. Software writes a word to one bus address. Each bit set to 1 in that word is a one-shot command, and each bit left at 0 does nothing. The block turns these strobes into lasting control levels: transmitter enable, receiver enable and a chip-select force. It also turns them into single-cycle pulses that reset the transmit path, reset the receive path and clear the overrun and underrun status flags.

Commands count only when the mode field from the mode register selects SPI host (0xE) or SPI client (0xF). The chip-select commands act only in host mode. Within one write, a disable bit beats the matching enable bit, a path reset beats both, and releasing the chip select beats forcing it. Every output is registered, so a command shows on the outputs in the cycle after the clock edge that samples the write.

Top module: `spi_cmd_reg`

## Requirements
- R1: After reset, tx_enable, rx_enable and cs_force are 0, and tx_reset_pulse, rx_reset_pulse and status_clear_pulse are 0.
- R2: A write counts only when wr_en is 1, wr_addr equals CMD_OFFSET (0x200) and mode is 0xE or 0xF. Any other write leaves every level unchanged and raises no pulse.
- R3: Data bit 6 sets tx_enable. Data bit 7 clears it. If both are 1 in the same write, tx_enable becomes 0.
- R4: Data bit 4 sets rx_enable. Data bit 5 clears it. If both are 1 in the same write, rx_enable becomes 0.
- R5: Data bit 3 raises tx_reset_pulse for one cycle and clears tx_enable, even when bit 6 is also set.
- R6: Data bit 2 raises rx_reset_pulse for one cycle and clears rx_enable, even when bit 4 is also set.
- R7: Data bit 8 raises status_clear_pulse for one cycle.
- R8: In mode 0xE, data bit 18 sets cs_force (select line held active) and data bit 19 clears it. If both are 1, cs_force becomes 0.
- R9: In mode 0xF, bits 18 and 19 leave cs_force unchanged, while the other command bits still act.
- R10: Data bits written as 0 have no effect. An accepted write of all zeros leaves every level unchanged.
- R11: Outputs change on the clock edge that samples the write. Pulses last exactly one cycle, and back-to-back commands give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data (command bits) |
| mode | input | 4 | Current mode field (0xE host, 0xF client) |
| tx_enable | output | 1 | Transmitter enable level |
| rx_enable | output | 1 | Receiver enable level |
| tx_reset_pulse | output | 1 | One-cycle transmit path reset |
| rx_reset_pulse | output | 1 | One-cycle receive path reset |
| status_clear_pulse | output | 1 | One-cycle clear of overrun and underrun flags |
| cs_force | output | 1 | 1 holds the chip-select line active (low) |

## Verification
The bench drives the priority collisions directly: enable with disable, enable with path reset, and force with release. A design that ranked these wrongly would leave a path enabled or the select line held. It writes chip-select commands in client mode, to the wrong address and in a non-SPI mode, where a design that skipped the qualification would change state. It follows each pulse with an idle cycle and a back-to-back repeat, which catches a pulse that sticks high or merges into one long pulse. It also writes all zeros, which catches a design that treats 0 bits as commands.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    // Command bit positions; software decodes these, so they are fixed.
    localparam int BIT_RST_RX     = 2;
    localparam int BIT_RST_TX     = 3;
    localparam int BIT_RX_EN      = 4;
    localparam int BIT_RX_DIS     = 5;
    localparam int BIT_TX_EN      = 6;
    localparam int BIT_TX_DIS     = 7;
    localparam int BIT_CLR_STAT   = 8;
    localparam int BIT_CS_FORCE   = 18;
    localparam int BIT_CS_RELEASE = 19;
    localparam int MIN_DATA_W     = BIT_CS_RELEASE + 1;

    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_SPI_HOST   = 4'hE;
    localparam logic [MODE_W-1:0] MODE_SPI_CLIENT = 4'hF;

    localparam int NUM_PATHS = 2;
    localparam int PATH_RX   = 0;
    localparam int PATH_TX   = 1;

    typedef struct packed {
        logic                 hit;
        logic [NUM_PATHS-1:0] path_en;
        logic [NUM_PATHS-1:0] path_dis;
        logic [NUM_PATHS-1:0] path_rst;
        logic                 clr_stat;
        logic                 cs_set;
        logic                 cs_clr;
    } cmd_strobe_t;

    typedef struct packed {
        logic enable;
        logic pulse;
    } path_state_t;

endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h200
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] mode,
    output cmd_strobe_t       strobe
);

    logic mode_spi;
    logic mode_host;
    logic hit;
    logic unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        mode_spi  = (mode == MODE_SPI_HOST) || (mode == MODE_SPI_CLIENT);
        mode_host = (mode == MODE_SPI_HOST);
        hit       = wr_en && (wr_addr == CMD_OFFSET) && mode_spi;

        strobe                    = '0;
        strobe.hit                = hit;
        strobe.path_rst[PATH_RX]  = hit && wr_data[BIT_RST_RX];
        strobe.path_rst[PATH_TX]  = hit && wr_data[BIT_RST_TX];
        strobe.path_en[PATH_RX]   = hit && wr_data[BIT_RX_EN];
        strobe.path_dis[PATH_RX]  = hit && wr_data[BIT_RX_DIS];
        strobe.path_en[PATH_TX]   = hit && wr_data[BIT_TX_EN];
        strobe.path_dis[PATH_TX]  = hit && wr_data[BIT_TX_DIS];
        strobe.clr_stat           = hit && wr_data[BIT_CLR_STAT];
        strobe.cs_set             = hit && mode_host && wr_data[BIT_CS_FORCE];
        strobe.cs_clr             = hit && mode_host && wr_data[BIT_CS_RELEASE];
    end

    initial begin
        if (DATA_W < MIN_DATA_W) $error("DATA_W too small for command bits");
    end

endmodule

// File: rtl/spi_cmd_path.sv
module spi_cmd_path
    import spi_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_stb,
    input  logic dis_stb,
    input  logic rst_stb,
    output logic enable,
    output logic rst_pulse
);

    path_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = rst_stb;
        if (rst_stb) begin
            st_d.enable = 1'b0;
        end else if (dis_stb) begin
            st_d.enable = 1'b0;
        end else if (en_stb) begin
            st_d.enable = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable    = st_q.enable;
    assign rst_pulse = st_q.pulse;

    // R5 R6
    rst_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> !enable);

    // R3 R4
    dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis_stb) |-> !enable);

    // R3 R4
    en_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_stb && !dis_stb && !rst_stb) |-> enable);

endmodule

// File: rtl/spi_cmd_cs.sv
module spi_cmd_cs (
    input  logic clk,
    input  logic rst_n,
    input  logic set_stb,
    input  logic clr_stb,
    output logic cs_force
);

    logic force_d, force_q;

    always_comb begin
        force_d = force_q;
        if (clr_stb)      force_d = 1'b0;
        else if (set_stb) force_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) force_q <= 1'b0;
        else        force_q <= force_d;
    end

    assign cs_force = force_q;

    // R8
    release_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_stb) |-> !cs_force);

    // R9
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(set_stb || clr_stb) |-> $stable(cs_force));

endmodule

// File: rtl/spi_cmd_reg.sv
module spi_cmd_reg
    import spi_cmd_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        mode,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              tx_reset_pulse,
    output logic              rx_reset_pulse,
    output logic              status_clear_pulse,
    output logic              cs_force
);

    cmd_strobe_t          strobe;
    logic [NUM_PATHS-1:0] path_enable;
    logic [NUM_PATHS-1:0] path_pulse;
    logic                 clr_d, clr_q;

    spi_cmd_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CMD_OFFSET (CMD_OFFSET)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode    (mode),
        .strobe  (strobe)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        spi_cmd_path u_path (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_stb    (strobe.path_en[p]),
            .dis_stb   (strobe.path_dis[p]),
            .rst_stb   (strobe.path_rst[p]),
            .enable    (path_enable[p]),
            .rst_pulse (path_pulse[p])
        );
    end

    spi_cmd_cs u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (strobe.cs_set),
        .clr_stb  (strobe.cs_clr),
        .cs_force (cs_force)
    );

    always_comb begin
        clr_d = strobe.clr_stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= clr_d;
    end

    assign tx_enable          = path_enable[PATH_TX];
    assign rx_enable          = path_enable[PATH_RX];
    assign tx_reset_pulse     = path_pulse[PATH_TX];
    assign rx_reset_pulse     = path_pulse[PATH_RX];
    assign status_clear_pulse = clr_q;

    // R2 R10
    no_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe.hit) |-> $stable({tx_enable, rx_enable, cs_force}));

    // R2 R11
    pulse_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_reset_pulse || rx_reset_pulse || status_clear_pulse) |-> $past(strobe.hit));

    // R7
    stat_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clear_pulse && !strobe.clr_stat) |=> !status_clear_pulse);

endmodule

// File: tb/spi_cmd_reg_tb.sv
module spi_cmd_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam logic [ADDR_W-1:0] OFFS = 12'h200;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [3:0]        mode = 4'hE;
    logic tx_enable, rx_enable, tx_reset_pulse, rx_reset_pulse;
    logic status_clear_pulse, cs_force;

    int checks = 0;
    int failures = 0;
    bit driver_done = 1'b0;

    // expected {tx, rx, cs, txp, rxp, stp}
    logic [5:0] exp_q[$];
    string      tag_q[$];
    logic m_tx = 0, m_rx = 0, m_cs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFFSET(OFFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .tx_enable(tx_enable),
        .rx_enable(rx_enable), .tx_reset_pulse(tx_reset_pulse),
        .rx_reset_pulse(rx_reset_pulse), .status_clear_pulse(status_clear_pulse),
        .cs_force(cs_force)
    );

    function automatic logic [5:0] actual();
        return {tx_enable, rx_enable, cs_force, tx_reset_pulse, rx_reset_pulse,
                status_clear_pulse};
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: one bus cycle, model computes expected outputs after the edge.
    task automatic drive(input logic en, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic [3:0] m,
                         input string tag);
        logic hit, txp, rxp, stp;
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; mode = m;
        hit = en && (a == OFFS) && (m == 4'hE || m == 4'hF);
        txp = hit && d[3];
        rxp = hit && d[2];
        stp = hit && d[8];
        if (txp)                m_tx = 0;
        else if (hit && d[7])   m_tx = 0;
        else if (hit && d[6])   m_tx = 1;
        if (rxp)                m_rx = 0;
        else if (hit && d[5])   m_rx = 0;
        else if (hit && d[4])   m_rx = 1;
        if (hit && m == 4'hE) begin
            if (d[19])      m_cs = 0;
            else if (d[18]) m_cs = 1;
        end
        @(posedge clk);
        exp_q.push_back({m_tx, m_rx, m_cs, txp, rxp, stp});
        tag_q.push_back(tag);
    endtask

    task automatic cmd(input logic [DATA_W-1:0] d, input logic [3:0] m, input string tag);
        drive(1'b1, OFFS, d, m, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, OFFS, '0, 4'hE, tag);
    endtask

    // Monitor: compare each expected item one half cycle after its edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) check(tag_q.pop_front(), actual(), exp_q.pop_front());
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", actual(), 6'b000000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", actual(), 6'b000000);

        cmd(32'h40, 4'hE, "R3 tx enable");
        cmd(32'h0, 4'hE, "R10 zero write holds");
        cmd(32'hC0, 4'hE, "R3 disable beats enable");
        cmd(32'h40, 4'hE, "R3 tx enable again");
        cmd(32'h80, 4'hE, "R3 tx disable");
        cmd(32'h10, 4'hE, "R4 rx enable");
        cmd(32'h30, 4'hE, "R4 disable beats enable");
        cmd(32'h10, 4'hE, "R4 rx enable again");
        cmd(32'h40, 4'hE, "R3 tx enable third");
        cmd(32'h48, 4'hE, "R5 tx reset beats enable");
        idle("R11 tx pulse one cycle");
        cmd(32'h14, 4'hE, "R6 rx reset beats enable");
        idle("R11 rx pulse one cycle");
        cmd(32'h100, 4'hE, "R7 status clear");
        idle("R7 status pulse ends");
        cmd(32'h100, 4'hE, "R11 back to back a");
        cmd(32'h108, 4'hE, "R11 back to back b");
        cmd(32'h40000, 4'hE, "R8 force cs");
        cmd(32'h0, 4'hE, "R10 zero keeps cs");
        cmd(32'h80000, 4'hE, "R8 release cs");
        cmd(32'h40000, 4'hE, "R8 force again");
        cmd(32'hC0000, 4'hE, "R8 release beats force");
        cmd(32'h40000, 4'hF, "R9 force ignored in client");
        cmd(32'h40050, 4'hF, "R9 enables act in client");
        cmd(32'h40000, 4'hE, "R8 force host");
        cmd(32'h80000, 4'hF, "R9 release ignored in client");
        drive(1'b1, 12'h204, 32'hFFFFFFFF, 4'hE, "R2 wrong address");
        drive(1'b1, OFFS, 32'hFFFFFFFF, 4'h3, "R2 non spi mode");
        drive(1'b0, OFFS, 32'hFFFFFFFF, 4'hE, "R2 no write strobe");
        cmd(32'h0, 4'hF, "R10 zero in client");
        cmd(32'hFFFFFFFF, 4'hE, "R5 R6 R8 all ones");
        idle("R11 final idle");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule